// File: doc/BRIEF.md
# Memory Replay Trap Detector

This block sits at the issue point of a two-pipe in-order integer core and decides, for each memory operation leaving issue, whether it must be thrown back to the front of the pipeline and replayed. Nothing after issue may stall, so any store or load that cannot be accepted by the store-side buffer or the outstanding-miss tracker is turned into a replay request instead.

Each cycle the block sees, for pipes E0 and E1, a valid bit, a 2-bit operation kind and an address. It also sees how many store-buffer slots are taken and which miss-tracker slots hold an outstanding miss, with their addresses. One clock later it presents a replay flag and a 2-bit cause per pipe. Stores replay when the store buffer has no free slot. Loads replay when the miss tracker is at its per-pipe limit, where E1 keeps one slot in reserve. Loads also replay when they fall into the same 8-byte block as any outstanding miss, so two loads to the same data cannot complete out of issue order. Hit, miss and merge outcomes play no part in any of these decisions.

Top module: `mem_replay_detect`

## Requirements
- R1: A valid store (op code 2'b10) on either pipe replays with cause 2'b01 when the store-buffer count is at least WB_ENTRIES (6), even if it could have merged; at a count of 5 it does not replay.
- R2: A valid load (op code 2'b01) on E0 replays with cause 2'b10 when all MAF_ENTRIES (6) miss-tracker slots are valid and no ordering match applies; with 5 valid it does not replay.
- R3: A valid load on E1 replays with cause 2'b10 when at least MAF_ENTRIES-E1_RESERVE (5) miss-tracker slots are valid and no ordering match applies.
- R4: A valid load whose address bits [ADDR_W-1:3] equal those of any valid miss-tracker slot replays with cause 2'b11; address bits [2:0] are ignored, invalid slots never match, and stores never take this cause.
- R5: When several causes apply to one operation a single replay is raised and the cause reported is the highest of ordering match (2'b11), miss tracker full (2'b10), store buffer full (2'b01).
- R6: An invalid slot, op code 2'b00 (none) or op code 2'b11 (non-memory) never replays and reports cause 2'b00.
- R7: Replay flag and cause appear exactly one clock after the issue-cycle inputs; during reset both are 0, and the replay flag is 1 exactly when the cause is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e0_vld | input | 1 | E0 issues an operation this cycle |
| e0_op | input | 2 | E0 op kind: 00 none, 01 load, 10 store, 11 non-memory |
| e0_addr | input | ADDR_W | E0 byte address |
| e1_vld | input | 1 | E1 issues an operation this cycle |
| e1_op | input | 2 | E1 op kind, same coding as E0 |
| e1_addr | input | ADDR_W | E1 byte address |
| wb_used | input | $clog2(WB_ENTRIES+1) | Store-buffer slots currently allocated |
| maf_vld | input | MAF_ENTRIES | Valid bit per miss-tracker slot |
| maf_addr | input | MAF_ENTRIES*ADDR_W | Miss-tracker slot addresses, slot i at bits [i*ADDR_W +: ADDR_W] |
| e0_replay | output | 1 | E0 operation of the previous cycle must replay |
| e0_cause | output | 2 | E0 cause: 00 none, 01 store buffer full, 10 miss tracker full, 11 ordering match |
| e1_replay | output | 1 | E1 operation of the previous cycle must replay |
| e1_cause | output | 2 | E1 cause, same coding |

## Verification
The ordering check and the miss-tracker occupancy check can both fire for one load in the same cycle, and the store-buffer check can fire on the other pipe at the same time. The bench provokes this by filling all six miss slots with one of them matching the load's 8-byte block while the store buffer is also full, then issuing a load and a store together on the two pipes. It judges the result against a scoreboard model built from the priority rule, expecting the ordering cause on the load and the store-buffer cause on the store in the following cycle.

// File: rtl/mem_replay_detect.sv
module mem_replay_detect #(
  parameter int WB_ENTRIES  = 6,
  parameter int MAF_ENTRIES = 6,
  parameter int E1_RESERVE  = 1,
  parameter int ADDR_W      = 32,
  localparam int WBC_W      = $clog2(WB_ENTRIES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          e0_vld,
  input  logic [1:0]                    e0_op,
  input  logic [ADDR_W-1:0]             e0_addr,
  input  logic                          e1_vld,
  input  logic [1:0]                    e1_op,
  input  logic [ADDR_W-1:0]             e1_addr,
  input  logic [WBC_W-1:0]              wb_used,
  input  logic [MAF_ENTRIES-1:0]        maf_vld,
  input  logic [MAF_ENTRIES*ADDR_W-1:0] maf_addr,
  output logic                          e0_replay,
  output logic [1:0]                    e0_cause,
  output logic                          e1_replay,
  output logic [1:0]                    e1_cause
);
  localparam int MC_W = $clog2(MAF_ENTRIES + 1);
  localparam logic [1:0] OP_LD = 2'b01;
  localparam logic [1:0] OP_ST = 2'b10;

  logic [MC_W-1:0] maf_cnt;
  logic            wb_full;

  always_comb begin
    maf_cnt = '0;
    for (int e = 0; e < MAF_ENTRIES; e++)
      maf_cnt = maf_cnt + MC_W'(maf_vld[e]);
  end

  assign wb_full = wb_used >= WBC_W'(WB_ENTRIES);

  logic [1:0]        pv;
  logic [1:0]        pop [2];
  logic [ADDR_W-1:0] pa  [2];
  logic [1:0]        rep_q;
  logic [1:0]        cau_q [2];

  assign pv     = {e1_vld, e0_vld};
  assign pop[0] = e0_op;
  assign pop[1] = e1_op;
  assign pa[0]  = e0_addr;
  assign pa[1]  = e1_addr;

  for (genvar p = 0; p < 2; p++) begin : g_pipe
    localparam int LIMIT = (p == 0) ? MAF_ENTRIES : MAF_ENTRIES - E1_RESERVE;
    logic       is_ld, is_st, ord_hit, maf_full;
    logic [1:0] cause_d;

    assign is_ld    = pv[p] && pop[p] == OP_LD;
    assign is_st    = pv[p] && pop[p] == OP_ST;
    assign maf_full = maf_cnt >= MC_W'(LIMIT);

    always_comb begin
      ord_hit = 1'b0;
      for (int e = 0; e < MAF_ENTRIES; e++)
        if (maf_vld[e] && maf_addr[e*ADDR_W+3 +: ADDR_W-3] == pa[p][ADDR_W-1:3])
          ord_hit = 1'b1;
    end

    always_comb begin
      if (is_ld && ord_hit)       cause_d = 2'b11;
      else if (is_ld && maf_full) cause_d = 2'b10;
      else if (is_st && wb_full)  cause_d = 2'b01;
      else                        cause_d = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rep_q[p] <= 1'b0;
        cau_q[p] <= 2'b00;
      end else begin
        rep_q[p] <= (is_ld && (ord_hit || maf_full)) || (is_st && wb_full);
        cau_q[p] <= cause_d;
      end
    end
  end

  assign e0_replay = rep_q[0];
  assign e1_replay = rep_q[1];
  assign e0_cause  = cau_q[0];
  assign e1_cause  = cau_q[1];
endmodule

module mem_replay_detect_chk #(
  parameter int WB_ENTRIES  = 6,
  parameter int MAF_ENTRIES = 6,
  parameter int E1_RESERVE  = 1,
  parameter int ADDR_W      = 32,
  localparam int WBC_W      = $clog2(WB_ENTRIES + 1)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          e0_vld,
  input logic [1:0]                    e0_op,
  input logic [ADDR_W-1:0]             e0_addr,
  input logic                          e1_vld,
  input logic [1:0]                    e1_op,
  input logic [ADDR_W-1:0]             e1_addr,
  input logic [WBC_W-1:0]              wb_used,
  input logic [MAF_ENTRIES-1:0]        maf_vld,
  input logic [MAF_ENTRIES*ADDR_W-1:0] maf_addr,
  input logic                          e0_replay,
  input logic [1:0]                    e0_cause,
  input logic                          e1_replay,
  input logic [1:0]                    e1_cause
);
  p_store_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (e0_vld && e0_op == 2'b10 && wb_used >= WBC_W'(WB_ENTRIES)) |=> (e0_replay && e0_cause == 2'b01));

  p_e0_maf_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (e0_vld && e0_op == 2'b01 && $countones(maf_vld) == MAF_ENTRIES) |=> (e0_replay && e0_cause[1]));

  p_e1_maf_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (e1_vld && e1_op == 2'b01 && $countones(maf_vld) >= MAF_ENTRIES - E1_RESERVE) |=> (e1_replay && e1_cause[1]));

  p_store_no_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (e1_vld && e1_op == 2'b10 && wb_used < WBC_W'(WB_ENTRIES)) |=> !e1_replay);

  p_e0_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!e0_vld || e0_op == 2'b00 || e0_op == 2'b11) |=> (!e0_replay && e0_cause == 2'b00));

  p_e1_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!e1_vld || e1_op == 2'b00 || e1_op == 2'b11) |=> (!e1_replay && e1_cause == 2'b00));

  p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (e0_replay == (e0_cause != 2'b00)) && (e1_replay == (e1_cause != 2'b00)));

  p_reset_clear_r7: assert property (@(posedge clk)
    !rst_n |=> (!e0_replay && !e1_replay && e0_cause == 2'b00 && e1_cause == 2'b00));
endmodule

bind mem_replay_detect mem_replay_detect_chk #(
  .WB_ENTRIES(WB_ENTRIES), .MAF_ENTRIES(MAF_ENTRIES),
  .E1_RESERVE(E1_RESERVE), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/mem_replay_detect_test.sv
module mem_replay_detect_test;
  localparam int WB = 6, MAF = 6, RES = 1, AW = 32;
  localparam int WBC_W = $clog2(WB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic e0_vld, e1_vld;
  logic [1:0] e0_op, e1_op;
  logic [AW-1:0] e0_addr, e1_addr;
  logic [WBC_W-1:0] wb_used;
  logic [MAF-1:0] maf_vld;
  logic [MAF*AW-1:0] maf_addr;
  logic e0_replay, e1_replay;
  logic [1:0] e0_cause, e1_cause;

  int total = 0, bad = 0;
  logic [5:0] q_exp[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  mem_replay_detect #(.WB_ENTRIES(WB), .MAF_ENTRIES(MAF), .E1_RESERVE(RES), .ADDR_W(AW)) uut (.*);

  function automatic logic [1:0] model(int pipe, logic v, logic [1:0] op, logic [AW-1:0] a);
    int  cnt = 0;
    logic ord = 1'b0;
    for (int e = 0; e < MAF; e++) begin
      cnt += maf_vld[e];
      if (maf_vld[e] && (maf_addr[e*AW +: AW] >> 3) == (a >> 3)) ord = 1'b1;
    end
    if (!v) return 2'b00;
    if (op == 2'b01 && ord) return 2'b11;
    if (op == 2'b01 && cnt >= ((pipe == 0) ? MAF : MAF - RES)) return 2'b10;
    if (op == 2'b10 && int'(wb_used) >= WB) return 2'b01;
    return 2'b00;
  endfunction

  task automatic issue(logic v0, logic [1:0] o0, logic [AW-1:0] a0,
                       logic v1, logic [1:0] o1, logic [AW-1:0] a1,
                       int wb, logic [MAF-1:0] mv, string tag);
    logic [1:0] c0, c1;
    e0_vld = v0; e0_op = o0; e0_addr = a0;
    e1_vld = v1; e1_op = o1; e1_addr = a1;
    wb_used = WBC_W'(wb); maf_vld = mv;
    c0 = model(0, v0, o0, a0);
    c1 = model(1, v1, o1, a1);
    q_exp.push_back({c0 != 2'b00, c0, c1 != 2'b00, c1});
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic check(logic [5:0] got, logic [5:0] exp, string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got r0=%b c0=%b r1=%b c1=%b expected r0=%b c0=%b r1=%b c1=%b",
               tag, got[5], got[4:3], got[2], got[1:0], exp[5], exp[4:3], exp[2], exp[1:0]);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0)
      check({e0_replay, e0_cause, e1_replay, e1_cause}, q_exp.pop_front(), q_tag.pop_front());
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL R7 watchdog expired: got hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int e = 0; e < MAF; e++) maf_addr[e*AW +: AW] = AW'(32'h0010_0000 + e * 32'h40);
    e0_vld = 0; e1_vld = 0; e0_op = 0; e1_op = 0; e0_addr = 0; e1_addr = 0;
    wb_used = WBC_W'(WB); maf_vld = '1;
    e0_vld = 1; e0_op = 2'b01; e1_vld = 1; e1_op = 2'b10;
    repeat (3) @(negedge clk);
    check({e0_replay, e0_cause, e1_replay, e1_cause}, 6'b0, "R7 reset state");
    rst_n = 1'b1;
    issue(0,0,0, 0,0,0, 0, '0, "R7 idle after reset");

    issue(1,2'b10,32'h200, 1,2'b10,32'h208, 5, '0, "R1 store below full");
    issue(1,2'b10,32'h200, 1,2'b10,32'h208, 6, '0, "R1 store buffer full");
    issue(1,2'b10,32'h0010_0000, 0,0,0, 6, '0, "R1 full even when mergeable");

    issue(1,2'b01,32'h500, 0,0,0, 0, 6'b011111, "R2 E0 load five valid");
    issue(1,2'b01,32'h500, 0,0,0, 0, 6'b111111, "R2 E0 load all valid");
    issue(0,0,0, 1,2'b01,32'h500, 0, 6'b111011, "R3 E1 load five valid");
    issue(1,2'b01,32'h500, 1,2'b01,32'h508, 0, 6'b101111, "R3 both pipes five valid");
    issue(0,0,0, 1,2'b01,32'h500, 0, 6'b001111, "R3 E1 load four valid");

    issue(1,2'b01,32'h0010_0007, 0,0,0, 0, 6'b000001, "R4 low bits ignored");
    issue(1,2'b01,32'h0010_0008, 0,0,0, 0, 6'b000001, "R4 next quadword no match");
    issue(0,0,0, 1,2'b01,32'h0010_0140, 0, 6'b100000, "R4 E1 match last slot");
    issue(1,2'b01,32'h0010_0080, 0,0,0, 0, 6'b111011, "R4 invalid slot no match");
    issue(1,2'b10,32'h0010_0000, 0,0,0, 0, 6'b000001, "R4 store no ordering trap");

    issue(1,2'b01,32'h0010_0043, 1,2'b10,32'h0010_0040, 6, 6'b111111, "R5 order over full both pipes");
    issue(0,0,0, 1,2'b01,32'h0010_00c1, 0, 6'b111111, "R5 order over maf full E1");
    issue(1,2'b01,32'h900, 1,2'b01,32'h908, 6, 6'b111111, "R5 maf full over store buffer");

    issue(1,2'b11,32'h0010_0000, 1,2'b00,32'h0010_0000, 6, 6'b111111, "R6 non-memory ops");
    issue(0,2'b01,32'h0010_0000, 0,2'b10,32'h0, 6, 6'b111111, "R6 invalid slots");
    issue(1,2'b01,32'h0010_0000, 1,2'b10,32'h0, 6, 6'b111111, "R7 back-to-back trap");
    issue(0,0,0, 0,0,0, 0, '0, "R7 clears next cycle");
    issue(0,0,0, 0,0,0, 0, '0, "R7 drain");

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule